// File: doc/BRIEF.md
# Vernier Trigger-to-Sample Interval Meter

This block finds the fine delay between an asynchronous trigger and the next rising edge of a free-running sampling clock. It is meant for equivalent-time acquisition, where many short captures of a repetitive signal are merged by time offset. When the trigger occurs, a second clock with a slightly longer period starts. The sampling-clock edges then gain on the trigger-clock edges by one period difference per cycle. The block counts cycles of both clocks until their rising edges line up. The delay is then the trigger-clock count times its period, minus the sampling-clock count times its period.

Periods are given in units of the period difference. With the defaults, the sampling clock is 99 units (9.9 ns), the trigger clock is 100 units (10 ns), and one unit is 100 ps. Line-up therefore comes within about 100 sampling cycles. A controller arms the block with a one-cycle pulse. The trigger clock must be stopped when the pulse is given. One trigger is then measured, and the block returns to idle. If the edges fail to meet within `LIMIT` sampling cycles, the measurement ends with an error.

Top module: `vernier_tdc`

## Requirements
- R1: After reset, `n_samp`, `n_trig` and `interval` are zero, and `done` and `err` are low.
- R2: Edge 0 is the first sampling edge at which `trig` is seen high while armed. Both clocks are counted from there. `n_samp` is the number of sampling periods from edge 0 to the sampling edge at which the captured trigger-clock level is high and the next capture is low. `n_trig` is the number of trigger-clock periods from the trigger to the trigger-clock edge that lines up with that sampling edge.
- R3: `interval` equals `n_trig*TRIG_U - n_samp*SAMP_U`.
- R4: The delay d runs from the trigger to edge 0. When d is not a whole number of units, `interval` equals d rounded up to whole units.
- R5: `done` is a single-cycle pulse. For a valid result it is high in the cycle after sampling edge `n_samp+4`, counted from edge 0.
- R6: Suppose no line-up is seen before sampling edge `LIMIT`. Then `err` and `done` are both high in the cycle after edge `LIMIT`, and the counts stay zero. `err` stays high until the next arm.
- R7: An arm pulse given while idle clears `n_samp`, `n_trig`, `interval` and `err` by the next cycle. A trigger given while the block is not armed starts nothing: no `done` follows, and the held outputs do not change.
- R8: An arm pulse given during a measurement is ignored, and the result is unaffected.
- R9: Only a high-to-low change in the captured trigger-clock level counts as line-up. The low-to-high change at the half-period crossing does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_s | input | 1 | Free-running sampling clock |
| clk_t | input | 1 | Gated trigger clock; its first rising edge is the trigger instant |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle arm strobe, sampling-clock domain |
| trig | input | 1 | Trigger level, held high from the trigger instant |
| n_samp | output | CW | Sampling-clock cycle count at line-up |
| n_trig | output | CW | Trigger-clock cycle count at line-up |
| interval | output | IW | Trigger-to-edge delay in period-difference units |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Line-up not found within LIMIT cycles |

## Verification
Line-up is detected one sampling edge after the second capture of the pair. Three further edges give the frozen trigger count time to settle. So for a result with count n, `done` is due after sampling edge n+4, and the bench expects its (n+5)th rising edge counted from edge 0. An aborted measurement signals after edge `LIMIT`, so the bench expects 129 edges with `LIMIT` = 128. The bench counts rising edges from the trigger and samples every output on the falling edge. Each result is compared in the cycle in which `done` is first seen high, and the bench checks that `done` is low again one cycle later.

// File: rtl/vernier_tdc.sv
`timescale 1ps/1ps
module vernier_tdc #(
  parameter int CW     = 8,
  parameter int IW     = 16,
  parameter int LIMIT  = 128,
  parameter int SAMP_U = 99,
  parameter int TRIG_U = 100
) (
  input  logic          clk_s,
  input  logic          clk_t,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          trig,
  output logic [CW-1:0] n_samp,
  output logic [CW-1:0] n_trig,
  output logic [IW-1:0] interval,
  output logic          done,
  output logic          err
);
  localparam int LAG = 3;

  typedef enum logic [1:0] {IDLE, ARMED, COUNT, SETTLE} st_t;
  st_t st;

  logic lvl, lvl_d;
  logic same;
  assign same = lvl_d & ~lvl;

  always_ff @(posedge clk_s or negedge rst_n)
    if (!rst_n) begin
      lvl   <= 1'b0;
      lvl_d <= 1'b0;
    end else begin
      lvl   <= clk_t;
      lvl_d <= lvl;
    end

  logic          clr, stop;
  logic          t_rst;
  logic [1:0]    sync;
  logic [CW-1:0] cnt_t;
  assign t_rst = ~rst_n | clr;

  always_ff @(posedge clk_t or posedge t_rst)
    if (t_rst) begin
      sync  <= 2'b00;
      cnt_t <= '0;
    end else begin
      sync <= {sync[0], stop};
      if (!sync[1] && cnt_t != '1) cnt_t <= cnt_t + 1'b1;
    end

  logic [CW-1:0] cnt_s, n1, n2;
  logic [1:0]    wcnt;
  logic [IW-1:0] prod;
  assign n2   = cnt_t - CW'(LAG);
  assign prod = IW'(n2) * IW'(TRIG_U) - IW'(n1) * IW'(SAMP_U);

  always_ff @(posedge clk_s or negedge rst_n)
    if (!rst_n) begin
      st       <= IDLE;
      cnt_s    <= '0;
      n1       <= '0;
      wcnt     <= '0;
      clr      <= 1'b0;
      stop     <= 1'b0;
      n_samp   <= '0;
      n_trig   <= '0;
      interval <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      clr  <= 1'b0;
      case (st)
        IDLE: if (arm) begin
          st       <= ARMED;
          clr      <= 1'b1;
          stop     <= 1'b0;
          n_samp   <= '0;
          n_trig   <= '0;
          interval <= '0;
          err      <= 1'b0;
        end
        ARMED: if (trig) begin
          st    <= COUNT;
          cnt_s <= '0;
        end
        COUNT:
          if (same) begin
            n1   <= cnt_s;
            stop <= 1'b1;
            wcnt <= '0;
            st   <= SETTLE;
          end else if (cnt_s == CW'(LIMIT - 1)) begin
            err  <= 1'b1;
            done <= 1'b1;
            st   <= IDLE;
          end else begin
            cnt_s <= cnt_s + 1'b1;
          end
        SETTLE:
          if (wcnt == 2'(LAG - 1)) begin
            n_samp   <= n1;
            n_trig   <= n2;
            interval <= prod;
            done     <= 1'b1;
            st       <= IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        default: st <= IDLE;
      endcase
    end

  logic st_idle, st_armed;
  assign st_idle  = (st == IDLE);
  assign st_armed = (st == ARMED);
endmodule

module vernier_tdc_chk #(
  parameter int CW    = 8,
  parameter int IW    = 16,
  parameter int LIMIT = 128
) (
  input logic          clk_s,
  input logic          rst_n,
  input logic          arm,
  input logic          trig,
  input logic [CW-1:0] n_samp,
  input logic [CW-1:0] n_trig,
  input logic [IW-1:0] interval,
  input logic          done,
  input logic          err,
  input logic          st_idle,
  input logic          st_armed
);
  logic [CW:0] cyc;
  always_ff @(posedge clk_s or negedge rst_n)
    if (!rst_n) cyc <= '0;
    else if (st_armed && trig) cyc <= '0;
    else if (cyc != '1) cyc <= cyc + 1'b1;

  assert_done_pulse_R5: assert property (@(posedge clk_s) disable iff (!rst_n)
    done |=> !done);
  assert_result_latency_R5: assert property (@(posedge clk_s) disable iff (!rst_n)
    (done && !err) |-> (cyc == {1'b0, n_samp} + (CW+1)'(4)));
  assert_abort_flag_R6: assert property (@(posedge clk_s) disable iff (!rst_n)
    $rose(err) |-> done);
  assert_abort_time_R6: assert property (@(posedge clk_s) disable iff (!rst_n)
    (done && err) |-> (cyc == (CW+1)'(LIMIT)));
  assert_arm_clear_R7: assert property (@(posedge clk_s) disable iff (!rst_n)
    (st_idle && arm) |=> (n_samp == '0 && n_trig == '0 && interval == '0 && !err));
  assert_idle_quiet_R7: assert property (@(posedge clk_s) disable iff (!rst_n)
    (st_idle && !done) |=> !done);
endmodule

bind vernier_tdc vernier_tdc_chk #(.CW(CW), .IW(IW), .LIMIT(LIMIT)) chk (
  .clk_s(clk_s), .rst_n(rst_n), .arm(arm), .trig(trig),
  .n_samp(n_samp), .n_trig(n_trig), .interval(interval),
  .done(done), .err(err), .st_idle(st_idle), .st_armed(st_armed)
);

// File: tb/vernier_tdc_test.sv
`timescale 1ps/1ps
module vernier_tdc_test;
  localparam int SP   = 4000;
  localparam int TP   = 4040;
  localparam int STEP = TP - SP;
  localparam int LIM  = 128;

  logic clk_s = 1'b0, clk_t = 1'b0, rst_n = 1'b0, arm = 1'b0, trig = 1'b0, run = 1'b0;
  logic [7:0]  n_samp, n_trig;
  logic [15:0] interval;
  logic        done, err;
  int errors = 0, checks = 0, cycles = 0;

  always #(SP/2) clk_s = ~clk_s;

  initial forever begin
    @(posedge run);
    while (run) begin
      clk_t = 1'b1; #(TP/2);
      clk_t = 1'b0; #(TP/2);
    end
  end

  vernier_tdc #(.SAMP_U(100), .TRIG_U(101), .LIMIT(LIM)) uut (
    .clk_s(clk_s), .clk_t(clk_t), .rst_n(rst_n), .arm(arm), .trig(trig),
    .n_samp(n_samp), .n_trig(n_trig), .interval(interval), .done(done), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_s) begin
    cycles++;
    if (cycles == 150000) begin
      errors++; checks++;
      $display("FAIL R5 watchdog actual=%0d expected=done", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic do_arm();
    @(negedge clk_s) arm = 1'b1;
    @(negedge clk_s) arm = 1'b0;
    repeat (2) @(negedge clk_s);
  endtask

  task automatic launch(input int d, input bit with_clk);
    @(posedge clk_s);
    #(SP - d);
    trig = 1'b1;
    run  = with_clk;
  endtask

  task automatic wait_done(output int edges, input bit mid_arm);
    edges = 0;
    forever begin
      @(posedge clk_s);
      edges++;
      @(negedge clk_s);
      arm = mid_arm && (edges == 5);
      if (done || edges > 300) break;
    end
    arm = 1'b0;
  endtask

  task automatic stop_run();
    run = 1'b0;
    trig = 1'b0;
    repeat (3) @(negedge clk_s);
  endtask

  task automatic idle_trigger(input int hold_n);
    bit seen = 0;
    launch(500, 1'b1);
    for (int i = 0; i < 150; i++) begin
      @(negedge clk_s);
      if (done) seen = 1;
    end
    chk("R7 no done without arm", int'(seen), 0);
    chk("R7 held count", int'(n_samp), hold_n);
    stop_run();
  endtask

  initial begin
    int edges, d, exp_n;
    repeat (3) @(negedge clk_s);
    chk("R1 n_samp", int'(n_samp), 0);
    chk("R1 n_trig", int'(n_trig), 0);
    chk("R1 interval", int'(interval), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk_s);

    idle_trigger(0);

    for (int m = 0; m < 100; m++) begin
      do_arm();
      d = m * STEP + 13;
      exp_n = (d + STEP - 1) / STEP;
      launch(d, 1'b1);
      wait_done(edges, 1'b0);
      chk(m >= 50 ? "R9 n_samp past half crossing" : "R2 n_samp", int'(n_samp), exp_n);
      chk("R2 n_trig", int'(n_trig), exp_n);
      chk("R3 interval formula", int'(interval), int'(n_trig) * 101 - int'(n_samp) * 100);
      chk("R4 interval rounding", int'(interval), exp_n);
      chk("R5 done latency", edges, exp_n + 5);
      chk("R6 err low", int'(err), 0);
      @(negedge clk_s);
      chk("R5 done width", int'(done), 0);
      stop_run();
    end

    idle_trigger(100);

    do_arm();
    chk("R7 arm clears n_samp", int'(n_samp), 0);
    chk("R7 arm clears interval", int'(interval), 0);
    launch(60 * STEP + 13, 1'b1);
    wait_done(edges, 1'b1);
    chk("R8 n_samp with stray arm", int'(n_samp), 61);
    chk("R8 interval with stray arm", int'(interval), 61);
    chk("R8 latency with stray arm", edges, 66);
    stop_run();

    do_arm();
    launch(500, 1'b0);
    wait_done(edges, 1'b0);
    chk("R6 err set", int'(err), 1);
    chk("R6 abort latency", edges, LIM + 1);
    chk("R6 n_samp zero", int'(n_samp), 0);
    chk("R6 n_trig zero", int'(n_trig), 0);
    stop_run();
    chk("R6 err sticky", int'(err), 1);
    do_arm();
    chk("R7 arm clears err", int'(err), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule